// File: doc/BRIEF.md
# Data-Strobe Link Character Receiver

This block turns an incoming data/strobe line pair into link characters. Both lines are synchronised into the system clock. Every change of the XOR of the two lines marks one received bit, whose value is the level of the data line. This is the two-phase equivalent of clocking on both edges of the recovered clock. At first the receiver only hunts for a NULL pattern. The first NULL fixes the character boundaries. After that, each character's length comes from its flag bit: 8 payload bits for data, 2 for control.

Data characters and packet-end markers go out as 9-bit receive FIFO write words. Flow-control tokens (FCT) and time codes are handed to the system side through two separate request/acknowledge pairs. A parity failure, or an escape followed by anything other than FCT or a data character, raises a receive error. The error also drops the alignment, so the receiver hunts for the next NULL. The link controller uses `null_seen` to start link initialisation.

Top module: `dsrx_rx`

## Requirements
- R1: While `rst_n` is low and after its release, before any line transition, all outputs are 0.
- R2: Until the first NULL has been found, no FIFO write, FCT request, time-code request, error or `null_seen` is produced, whatever characters arrive.
- R3: In hunt mode, the bit sequence 1,1,1,0,1,0,0 (the flag and code of an escape, then a correct-parity FCT) aligns the receiver. The receiver then sets `null_seen` and pulses `null_pulse` for one cycle.
- R4: Each character is sent as parity bit, flag bit, payload. A data character has flag 0 and 8 bits, least significant first. It produces one `fifo_wr` with `fifo_wdata = {1'b0, byte}`, in arrival order.
- R5: A control character has flag 1 and 2 code bits, first bit is the code MSB: FCT=00, EOP=01, EEP=10, ESC=11. EOP writes 9'h100 and EEP writes 9'h101. Bit 8 marks a packet end.
- R6: A received FCT raises `fct_req`, which stays high until `fct_ack` is seen and then falls on the next clock.
- R7: ESC followed by a data character is a time code. `tc_req` rises with `tc_time = byte[5:0]` and `tc_flags = byte[7:6]`. Both values are held stable until the request falls after `tc_ack`.
- R8: An FCT or time code that arrives while its handshake is still open is dropped, and the held values are kept.
- R9: Odd parity covers the previous character's payload plus the current parity and flag bits. A failure pulses `rx_err`, clears `null_seen`, and every character is ignored until the next NULL.
- R10: ESC followed by EOP, EEP or another ESC pulses `rx_err` and clears `null_seen`.
- R11: One bit is taken per change of either line. The gap between changes may vary freely, down to two clock cycles.
- R12: A NULL received while aligned pulses `null_pulse` and raises no FCT request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ds_d | input | 1 | Incoming data line |
| ds_s | input | 1 | Incoming strobe line |
| null_seen | output | 1 | Character boundaries are locked |
| null_pulse | output | 1 | One-cycle pulse per received NULL |
| fifo_wr | output | 1 | Receive FIFO write strobe |
| fifo_wdata | output | 9 | FIFO word: bit 8 packet end, bits 7:0 data or end kind |
| rx_err | output | 1 | One-cycle pulse on parity or escape error |
| fct_req | output | 1 | FCT received, waiting for acknowledge |
| fct_ack | input | 1 | System-side acknowledge of `fct_req` |
| tc_req | output | 1 | Time code held, waiting for acknowledge |
| tc_ack | input | 1 | System-side acknowledge of `tc_req` |
| tc_time | output | 6 | Time value of the held time code |
| tc_flags | output | 2 | Control flags of the held time code |

## Verification
The hardest situation to reach is a second time code that arrives while the first handshake is still open. On the system side the acknowledge comes back within a few cycles, far sooner than a character lasts. The bench therefore withholds its automatic acknowledge, sends two time codes back to back, and checks that the held values belong to the first. Parity errors take similar care, because parity runs across character boundaries. The bench keeps its own running payload parity and corrupts exactly one parity bit, then checks that the stream following it stays silent until a fresh NULL.

// File: rtl/dsrx_pkg.sv
`timescale 1ns/1ps
package dsrx_pkg;
  localparam int DATA_BITS = 8;
  localparam int CTRL_BITS = 2;
  localparam int NULL_LEN  = 7;
  localparam logic [NULL_LEN-1:0] NULL_TAIL = 7'b1110100;

  localparam logic [1:0] CC_FCT = 2'b00;
  localparam logic [1:0] CC_EOP = 2'b01;
  localparam logic [1:0] CC_EEP = 2'b10;
  localparam logic [1:0] CC_ESC = 2'b11;

  typedef enum logic [1:0] {ST_HUNT, ST_HEAD, ST_BODY} rx_state_e;

  typedef enum logic [3:0] {
    EV_NONE, EV_DATA, EV_EOP, EV_EEP, EV_FCT, EV_NULL, EV_TIME, EV_ESC, EV_ERR
  } rx_event_e;

  // odd parity over previous payload, current parity bit and current flag
  function automatic logic parity_good(logic prev_pay, logic pbit, logic flag);
    return prev_pay ^ pbit ^ flag;
  endfunction

  function automatic rx_event_e classify(logic esc, logic par_ok, logic flag,
                                         logic [1:0] code);
    if (!par_ok) return EV_ERR;
    if (!flag) return esc ? EV_TIME : EV_DATA;
    case (code)
      CC_FCT:  return esc ? EV_NULL : EV_FCT;
      CC_EOP:  return esc ? EV_ERR : EV_EOP;
      CC_EEP:  return esc ? EV_ERR : EV_EEP;
      default: return esc ? EV_ERR : EV_ESC;
    endcase
  endfunction

  function automatic logic [8:0] fifo_word(rx_event_e ev, logic [7:0] b);
    case (ev)
      EV_DATA: return {1'b0, b};
      EV_EOP:  return 9'h100;
      EV_EEP:  return 9'h101;
      default: return 9'h000;
    endcase
  endfunction
endpackage

// File: rtl/dsrx_bit_recover.sv
`timescale 1ns/1ps
module dsrx_bit_recover #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ds_d,
  input  logic ds_s,
  output logic bit_stb,
  output logic bit_val
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] d_pipe, s_pipe;
  logic         phase_q;
  logic         phase_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d_pipe  <= '0;
      s_pipe  <= '0;
      phase_q <= 1'b0;
    end else begin
      d_pipe  <= {d_pipe[TOP-1:0], ds_d};
      s_pipe  <= {s_pipe[TOP-1:0], ds_s};
      phase_q <= phase_now;
    end
  end

  // recovered clock level; each change of it carries one bit
  assign phase_now = d_pipe[TOP] ^ s_pipe[TOP];
  assign bit_stb   = phase_now != phase_q;
  assign bit_val   = d_pipe[TOP];
endmodule

// File: rtl/dsrx_char_decoder.sv
`timescale 1ns/1ps
module dsrx_char_decoder
  import dsrx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_stb,
  input  logic       bit_val,
  output logic       aligned,
  output rx_event_e  ev,
  output logic [7:0] ev_byte
);
  localparam int CW = $clog2(DATA_BITS);

  rx_state_e             st_q;
  logic [NULL_LEN-2:0]   win_q;
  logic [CW-1:0]         cnt_q;
  logic [DATA_BITS-1:0]  body_q;
  logic                  par_q, flag_q, esc_q, prev_pay_q;

  logic [DATA_BITS-1:0]  nb;
  logic [CW-1:0]         last;
  logic [1:0]            code;
  logic                  pay_par;
  logic                  null_hit;
  rx_event_e             kind;

  always_comb begin
    nb       = {bit_val, body_q[DATA_BITS-1:1]};
    last     = flag_q ? CW'(CTRL_BITS - 1) : CW'(DATA_BITS - 1);
    code     = {nb[DATA_BITS-2], nb[DATA_BITS-1]};
    pay_par  = flag_q ? ^nb[DATA_BITS-1:DATA_BITS-2] : ^nb;
    kind     = classify(esc_q, parity_good(prev_pay_q, par_q, flag_q), flag_q, code);
    null_hit = {win_q, bit_val} == NULL_TAIL;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_HUNT;
      win_q      <= '0;
      cnt_q      <= '0;
      body_q     <= '0;
      par_q      <= 1'b0;
      flag_q     <= 1'b0;
      esc_q      <= 1'b0;
      prev_pay_q <= 1'b0;
      aligned    <= 1'b0;
      ev         <= EV_NONE;
      ev_byte    <= '0;
    end else begin
      ev <= EV_NONE;
      if (bit_stb) begin
        case (st_q)
          ST_HUNT: begin
            win_q <= {win_q[NULL_LEN-3:0], bit_val};
            if (null_hit) begin
              st_q       <= ST_HEAD;
              win_q      <= '0;
              cnt_q      <= '0;
              aligned    <= 1'b1;
              esc_q      <= 1'b0;
              prev_pay_q <= 1'b0;
              ev         <= EV_NULL;
            end
          end
          ST_HEAD: begin
            if (cnt_q == '0) begin
              par_q <= bit_val;
              cnt_q <= CW'(1);
            end else begin
              flag_q <= bit_val;
              cnt_q  <= '0;
              st_q   <= ST_BODY;
            end
          end
          default: begin
            body_q <= nb;
            if (cnt_q == last) begin
              cnt_q      <= '0;
              prev_pay_q <= pay_par;
              ev         <= kind;
              ev_byte    <= nb;
              esc_q      <= kind == EV_ESC;
              st_q       <= ST_HEAD;
              if (kind == EV_ERR) begin
                st_q    <= ST_HUNT;
                aligned <= 1'b0;
                win_q   <= '0;
              end
            end else begin
              cnt_q <= cnt_q + CW'(1);
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/dsrx_req_ack.sv
`timescale 1ns/1ps
module dsrx_req_ack (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic ack,
  output logic req
);
  // four-phase: new request only once ack has returned low
  always_ff @(posedge clk) begin
    if (!rst_n)            req <= 1'b0;
    else if (req)          req <= !ack;
    else if (evt && !ack)  req <= 1'b1;
  end
endmodule

// File: rtl/dsrx_rx.sv
`timescale 1ns/1ps
module dsrx_rx
  import dsrx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ds_d,
  input  logic       ds_s,
  output logic       null_seen,
  output logic       null_pulse,
  output logic       fifo_wr,
  output logic [8:0] fifo_wdata,
  output logic       rx_err,
  output logic       fct_req,
  input  logic       fct_ack,
  output logic       tc_req,
  input  logic       tc_ack,
  output logic [5:0] tc_time,
  output logic [1:0] tc_flags
);
  logic       bit_stb, bit_val;
  rx_event_e  ev;
  logic [7:0] ev_byte;
  logic [7:0] tc_hold_q;
  logic       fct_evt, tc_evt;

  dsrx_bit_recover #(.SYNC_STAGES(SYNC_STAGES)) u_bits (
    .clk(clk), .rst_n(rst_n), .ds_d(ds_d), .ds_s(ds_s),
    .bit_stb(bit_stb), .bit_val(bit_val)
  );

  dsrx_char_decoder u_dec (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(bit_val),
    .aligned(null_seen), .ev(ev), .ev_byte(ev_byte)
  );

  assign fct_evt    = ev == EV_FCT;
  assign tc_evt     = ev == EV_TIME;
  assign null_pulse = ev == EV_NULL;
  assign rx_err     = ev == EV_ERR;
  assign fifo_wr    = (ev == EV_DATA) || (ev == EV_EOP) || (ev == EV_EEP);
  assign fifo_wdata = fifo_word(ev, ev_byte);

  dsrx_req_ack u_fct_hs (
    .clk(clk), .rst_n(rst_n), .evt(fct_evt), .ack(fct_ack), .req(fct_req)
  );

  dsrx_req_ack u_tc_hs (
    .clk(clk), .rst_n(rst_n), .evt(tc_evt), .ack(tc_ack), .req(tc_req)
  );

  // held value may only change while no request is outstanding
  always_ff @(posedge clk) begin
    if (!rst_n)                 tc_hold_q <= '0;
    else if (tc_evt && !tc_req) tc_hold_q <= ev_byte;
  end

  assign tc_time  = tc_hold_q[5:0];
  assign tc_flags = tc_hold_q[7:6];
endmodule

// File: rtl/dsrx_rx_checker.sv
`timescale 1ns/1ps
module dsrx_rx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       null_seen,
  input logic       null_pulse,
  input logic       fifo_wr,
  input logic [8:0] fifo_wdata,
  input logic       rx_err,
  input logic       fct_req,
  input logic       fct_ack,
  input logic       tc_req,
  input logic       tc_ack,
  input logic [5:0] tc_time,
  input logic [1:0] tc_flags
);
  assert_wr_needs_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> $past(null_seen));

  assert_null_locks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    null_pulse |-> null_seen);

  assert_one_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fifo_wr, null_pulse, rx_err}));

  assert_end_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && fifo_wdata[8]) |-> (fifo_wdata[7:1] == 7'd0));

  assert_fct_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fct_req && !fct_ack) |=> fct_req);

  assert_fct_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fct_req && fct_ack) |=> !fct_req);

  assert_tc_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_req && !tc_ack) |=> $stable({tc_flags, tc_time}));

  assert_tc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_req && !tc_ack) |=> tc_req);

  assert_tc_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_req && tc_ack) |=> !tc_req);

  assert_err_unlocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |-> !null_seen);
endmodule

bind dsrx_rx dsrx_rx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .null_seen(null_seen), .null_pulse(null_pulse),
  .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .rx_err(rx_err),
  .fct_req(fct_req), .fct_ack(fct_ack), .tc_req(tc_req), .tc_ack(tc_ack),
  .tc_time(tc_time), .tc_flags(tc_flags)
);

// File: tb/dsrx_rx_bench.sv
`timescale 1ns/1ps
module dsrx_rx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ds_d = 1'b0, ds_s = 1'b0;
  logic       null_seen, null_pulse, fifo_wr, rx_err, fct_req, tc_req;
  logic       fct_ack = 1'b0, tc_ack = 1'b0;
  logic [8:0] fifo_wdata;
  logic [5:0] tc_time;
  logic [1:0] tc_flags;

  int checks = 0, errors = 0;
  int fifo_n = 0, null_n = 0, err_n = 0, fct_n = 0, tc_n = 0;
  logic [8:0] fifo_log [0:1023];
  logic [7:0] tc_log [0:511];
  bit   tc_auto = 1'b1;
  bit   done = 1'b0;
  logic prevpar = 1'b0;

  always #2.5 clk = ~clk;

  dsrx_rx u_dsrx_rx (
    .clk(clk), .rst_n(rst_n), .ds_d(ds_d), .ds_s(ds_s),
    .null_seen(null_seen), .null_pulse(null_pulse), .fifo_wr(fifo_wr),
    .fifo_wdata(fifo_wdata), .rx_err(rx_err), .fct_req(fct_req),
    .fct_ack(fct_ack), .tc_req(tc_req), .tc_ack(tc_ack),
    .tc_time(tc_time), .tc_flags(tc_flags)
  );

  // monitor and system-side acknowledge, away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      fct_ack = 1'b0;
      tc_ack  = 1'b0;
    end else begin
      if (fifo_wr) begin
        if (fifo_n < 1024) fifo_log[fifo_n] = fifo_wdata;
        fifo_n++;
      end
      if (null_pulse) null_n++;
      if (rx_err) err_n++;
      if (fct_req && !fct_ack) begin
        fct_ack = 1'b1;
        fct_n++;
      end else if (!fct_req) fct_ack = 1'b0;
      if (tc_req && !tc_ack && tc_auto) begin
        tc_ack = 1'b1;
        if (tc_n < 512) tc_log[tc_n] = {tc_flags, tc_time};
        tc_n++;
      end else if (!tc_req) tc_ack = 1'b0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input int gap);
    @(negedge clk);
    if (b != ds_d) ds_d = ~ds_d;
    else           ds_s = ~ds_s;
    repeat (gap - 1) @(negedge clk);
  endtask

  task automatic send_data(input logic [7:0] b, input int gap, input bit badpar);
    send_bit(~prevpar ^ badpar, gap);
    send_bit(1'b0, gap);
    for (int i = 0; i < 8; i++) send_bit(b[i], gap);
    prevpar = ^b;
  endtask

  task automatic send_ctl(input logic [1:0] c);
    send_bit(prevpar, 4);
    send_bit(1'b1, 4);
    send_bit(c[1], 4);
    send_bit(c[0], 4);
    prevpar = c[1] ^ c[0];
  endtask

  task automatic send_null();
    send_ctl(2'b11);
    send_ctl(2'b00);
  endtask

  task automatic send_tc(input logic [7:0] b);
    send_ctl(2'b11);
    send_data(b, 4, 1'b0);
  endtask

  task automatic settle();
    repeat (10) @(negedge clk);
  endtask

  initial begin
    int base, ebase, tbase, fbase, nbase;
    repeat (4) @(negedge clk);
    chk("R1 null_seen in reset", null_seen, 0);
    chk("R1 fifo_wr in reset", fifo_wr, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 outputs after reset", {null_seen, null_pulse, fifo_wr, rx_err, fct_req, tc_req}, 0);
    chk("R1 fifo_wdata", fifo_wdata, 0);
    chk("R1 time code", {tc_flags, tc_time}, 0);

    // R2: traffic before any NULL
    send_data(8'h00, 4, 1'b0);
    send_data(8'h55, 4, 1'b0);
    send_data(8'hAA, 4, 1'b0);
    send_ctl(2'b01);
    settle();
    chk("R2 no fifo write", fifo_n, 0);
    chk("R2 no null", null_n + err_n + fct_n + tc_n, 0);
    chk("R2 not locked", null_seen, 0);

    // R3: a little preamble, then the first NULL
    send_bit(1'b0, 4); send_bit(1'b1, 4); send_bit(1'b0, 4);
    send_null();
    settle();
    chk("R3 locked", null_seen, 1);
    chk("R3 null pulses", null_n, 1);
    chk("R3 no fct from null", fct_n, 0);

    // R4: every data byte
    base = fifo_n;
    for (int v = 0; v < 256; v++) send_data(v[7:0], 4, 1'b0);
    settle();
    chk("R4 write count", fifo_n - base, 256);
    for (int v = 0; v < 256; v++) chk("R4 data word", fifo_log[base + v], v);

    // R5: packet ends
    base = fifo_n;
    send_ctl(2'b01);
    send_ctl(2'b10);
    settle();
    chk("R5 end count", fifo_n - base, 2);
    chk("R5 EOP word", fifo_log[base], 9'h100);
    chk("R5 EEP word", fifo_log[base + 1], 9'h101);

    // R6: FCT handshakes
    base = fifo_n;
    for (int k = 0; k < 3; k++) send_ctl(2'b00);
    settle();
    chk("R6 fct count", fct_n, 3);
    chk("R6 fct req released", fct_req, 0);
    chk("R6 no fifo write", fifo_n - base, 0);

    // R12: NULL while locked
    nbase = null_n; fbase = fct_n;
    send_null();
    settle();
    chk("R12 null pulse", null_n - nbase, 1);
    chk("R12 no fct", fct_n - fbase, 0);

    // R7: every time code
    tbase = tc_n;
    for (int v = 0; v < 256; v++) send_tc(v[7:0]);
    settle();
    chk("R7 tc count", tc_n - tbase, 256);
    for (int v = 0; v < 256; v++) chk("R7 time code", tc_log[tbase + v], v);

    // R8: second time code while handshake held open
    tc_auto = 1'b0;
    tbase = tc_n;
    send_tc(8'h2A);
    settle();
    chk("R8 req held", tc_req, 1);
    chk("R8 time", tc_time, 6'h2A);
    send_tc(8'hC5);
    settle();
    chk("R8 time kept", tc_time, 6'h2A);
    chk("R8 flags kept", tc_flags, 0);
    tc_auto = 1'b1;
    settle();
    chk("R8 one delivered", tc_n - tbase, 1);
    chk("R8 delivered value", tc_log[tbase], 8'h2A);
    chk("R8 released", tc_req, 0);
    send_tc(8'hC5);
    settle();
    chk("R8 next delivered", tc_log[tbase + 1], 8'hC5);

    // R11: uneven bit spacing
    base = fifo_n;
    for (int v = 0; v < 64; v++) send_data(8'(v * 37 + 11), 2 + (v % 8), 1'b0);
    settle();
    chk("R11 write count", fifo_n - base, 64);
    for (int v = 0; v < 64; v++) chk("R11 data word", fifo_log[base + v], (v * 37 + 11) % 256);

    // R9: parity error and silence until next NULL
    ebase = err_n; base = fifo_n;
    send_data(8'h00, 4, 1'b1);
    settle();
    chk("R9 error pulse", err_n - ebase, 1);
    chk("R9 unlocked", null_seen, 0);
    send_data(8'h5A, 4, 1'b0);
    settle();
    chk("R9 ignored", fifo_n - base, 0);
    send_null();
    send_data(8'h33, 4, 1'b0);
    settle();
    chk("R9 relocked", null_seen, 1);
    chk("R9 data after relock", fifo_log[fifo_n - 1], 9'h033);

    // R10: escape misuse
    ebase = err_n;
    send_ctl(2'b11); send_ctl(2'b01);
    settle();
    chk("R10 esc eop error", err_n - ebase, 1);
    chk("R10 unlocked", null_seen, 0);
    send_null();
    send_ctl(2'b11); send_ctl(2'b11);
    settle();
    chk("R10 esc esc error", err_n - ebase, 2);
    send_null();
    send_ctl(2'b11); send_ctl(2'b10);
    settle();
    chk("R10 esc eep error", err_n - ebase, 3);
    chk("R10 unlocked again", null_seen, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule